// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two-channel serial audio stream (a bit clock, a word clock and one data line) into parallel samples. It runs on a fast system clock. It watches the bit clock for rising edges and samples the word clock and the data line at those instants only. Data is two's complement and MSB first. The left and right samples take turns, one in each half of the word-clock period.

Three static pins choose one of five framings:

- Right-justified at 16, 20 or 24 bits. The sample is the last N bits before a word-clock change.
- Left-justified. The first 16 bits after a word-clock change are kept.
- I2S. There is a one-bit delay after the word-clock change, 16 bits are kept, and the left channel is on the low word-clock level.

Every sample leaves as a 24-bit word with its MSB at bit 23 and zeros below the captured bits. It comes with a one-cycle valid strobe and a channel flag. A frame strobe marks the completion of each right-channel sample.

Top module: `audio_ser_rx`

## Requirements
- R1: While reset is asserted, the sample word reads zero and the sample strobe and frame strobe are both low.
- R2: With the I2S pin high, the block uses I2S framing for every value of the two format pins.
- R3: With (fmt_m0_i, fmt_m1_i, fmt_i2s_i) = (0,0,0), the 16 bits received last before a word-clock change appear on bits 23..8, and bits 7..0 are zero.
- R4: With (1,0,0), the 20 bits received last before a word-clock change appear on bits 23..4, and bits 3..0 are zero.
- R5: With (0,1,0), the 24 bits received last before a word-clock change appear on bits 23..0.
- R6: Right-justified results are the same for any number of bit-clock edges per half-frame, from the format's width up to 32.
- R7: With (1,1,0), the 16 bits taken on the first 16 rising edges after a word-clock change appear on bits 23..8, and later bits of that half are ignored.
- R8: In I2S framing, the MSB is the bit taken on the second rising edge after a word-clock change, the following 15 bits complete the sample, and bits 7..0 are zero.
- R9: smp_left_o is 1 for a left sample. Left is a high word clock in the non-I2S framings and a low word clock in I2S. A right-justified sample belongs to the half that has just ended.
- R10: Each completed half-frame produces exactly one single-cycle smp_valid_o pulse. frame_valid_o pulses only together with a right-channel sample, and the sample word changes only with a pulse.
- R11: After reset, no sample is produced for the half-frame in which the first word-clock change has not yet been seen.
- R12: The data line is sampled only at rising bit-clock edges, so data changes while the bit clock is high do not alter any sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock, one period per stereo frame |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_m0_i | input | 1 | Format select bit 0 |
| fmt_m1_i | input | 1 | Format select bit 1 |
| fmt_i2s_i | input | 1 | I2S select, overrides the other two |
| smp_data_o | output | 24 | Received sample, MSB at bit 23 |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| smp_left_o | output | 1 | Channel of the current sample, 1 = left |
| frame_valid_o | output | 1 | One-cycle strobe when a right sample completes |

## Verification
The assertions rely on three properties of the inputs:

- Rising bit-clock edges are at least two system clocks apart. Without this, the single-pulse rule on the sample strobe could not hold.
- The format pins change only while reset is asserted. The zero-fill checks depend on this.
- The word clock never changes in the same system-clock sample as a rising bit-clock edge.

The stimulus holds the bit clock high and low for two system clocks each. It moves the word clock only together with a falling bit-clock edge. It sets the format pins during reset before each sweep, and it flips the data line partway through every high phase to exercise R12.

// File: rtl/asr_pkg.sv
`timescale 1ns/1ps
package asr_pkg;

    localparam int DATA_W  = 24;
    localparam int SLOT_W  = 5;
    localparam int SHAMT_W = $clog2(DATA_W + 1);
    localparam int NARROW_W = 16;
    localparam int MID_W    = 20;

    typedef enum logic [2:0] {
        FMT_RJ16,
        FMT_RJ20,
        FMT_RJ24,
        FMT_LJ16,
        FMT_I2S16
    } fmt_e;

    typedef struct packed {
        logic               is_rj;
        logic               left_hi;
        logic [SHAMT_W-1:0] shamt;
        logic [SLOT_W-1:0]  last_idx;
    } fmt_cfg_t;

    typedef struct packed {
        logic sck;
        logic ws;
        logic sd;
    } line_t;

endpackage

// File: rtl/asr_edge_sync.sv
`timescale 1ns/1ps
module asr_edge_sync
    import asr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic ws_o,
    output logic sd_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        line_t [STAGES-1:0] pipe;
        logic               sck_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = '{sck: sck_i, ws: ws_i, sd: sd_i};
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.sck_prev = st_q.pipe[LAST].sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.pipe[LAST].sck & ~st_q.sck_prev;
    assign ws_o   = st_q.pipe[LAST].ws;
    assign sd_o   = st_q.pipe[LAST].sd;

endmodule

// File: rtl/asr_mode_dec.sv
`timescale 1ns/1ps
module asr_mode_dec
    import asr_pkg::*;
(
    input  logic     m0_i,
    input  logic     m1_i,
    input  logic     i2s_i,
    output fmt_cfg_t cfg_o
);

    localparam logic [SHAMT_W-1:0] SH_NARROW = SHAMT_W'(DATA_W - NARROW_W);
    localparam logic [SHAMT_W-1:0] SH_MID    = SHAMT_W'(DATA_W - MID_W);
    localparam logic [SLOT_W-1:0]  LJ_LAST   = SLOT_W'(NARROW_W - 1);
    localparam logic [SLOT_W-1:0]  I2S_LAST  = SLOT_W'(NARROW_W);

    fmt_e fmt;

    always_comb begin
        if (i2s_i) begin
            fmt = FMT_I2S16;
        end else begin
            case ({m1_i, m0_i})
                2'b00:   fmt = FMT_RJ16;
                2'b01:   fmt = FMT_RJ20;
                2'b10:   fmt = FMT_RJ24;
                default: fmt = FMT_LJ16;
            endcase
        end
    end

    always_comb begin
        cfg_o = '{is_rj: 1'b1, left_hi: 1'b1, shamt: SH_NARROW, last_idx: '0};
        case (fmt)
            FMT_RJ16: cfg_o.shamt = SH_NARROW;
            FMT_RJ20: cfg_o.shamt = SH_MID;
            FMT_RJ24: cfg_o.shamt = '0;
            FMT_LJ16: begin
                cfg_o.is_rj    = 1'b0;
                cfg_o.last_idx = LJ_LAST;
            end
            default: begin
                cfg_o.is_rj    = 1'b0;
                cfg_o.left_hi  = 1'b0;
                cfg_o.last_idx = I2S_LAST;
            end
        endcase
    end

endmodule

// File: rtl/asr_deser.sv
`timescale 1ns/1ps
module asr_deser
    import asr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              ws_i,
    input  logic              sd_i,
    input  fmt_cfg_t          cfg_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              left_o,
    output logic              frame_o
);

    localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [SLOT_W-1:0] cnt;
        logic              ws_prev;
        logic              have_prev;
        logic              armed;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              left;
        logic              frame;
    } deser_st_t;

    deser_st_t st_d, st_q;

    logic              trans;
    logic              emit;
    logic              emit_left;
    logic [SLOT_W-1:0] idx;
    logic [DATA_W-1:0] src;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.frame = 1'b0;
        trans      = 1'b0;
        emit       = 1'b0;
        emit_left  = 1'b0;
        idx        = '0;
        src        = '0;
        if (rise_i) begin
            trans          = st_q.have_prev && (ws_i != st_q.ws_prev);
            idx            = trans ? '0 : st_q.cnt;
            st_d.have_prev = 1'b1;
            st_d.ws_prev   = ws_i;
            st_d.shreg     = {st_q.shreg[DATA_W-2:0], sd_i};
            st_d.cnt       = (idx == SLOT_MAX) ? idx : idx + 1'b1;
            if (trans) begin
                st_d.armed = 1'b1;
            end
            if (cfg_i.is_rj) begin
                emit      = trans && st_q.armed;
                src       = st_q.shreg;
                emit_left = (st_q.ws_prev == cfg_i.left_hi);
            end else begin
                emit      = st_q.armed && (idx == cfg_i.last_idx);
                src       = st_d.shreg;
                emit_left = (ws_i == cfg_i.left_hi);
            end
            if (emit) begin
                st_d.data  = src << cfg_i.shamt;
                st_d.valid = 1'b1;
                st_d.left  = emit_left;
                st_d.frame = ~emit_left;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign left_o  = st_q.left;
    assign frame_o = st_q.frame;

endmodule

// File: rtl/audio_ser_rx.sv
`timescale 1ns/1ps
module audio_ser_rx
    import asr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              wclk_i,
    input  logic              sdata_i,
    input  logic              fmt_m0_i,
    input  logic              fmt_m1_i,
    input  logic              fmt_i2s_i,
    output logic [DATA_W-1:0] smp_data_o,
    output logic              smp_valid_o,
    output logic              smp_left_o,
    output logic              frame_valid_o
);

    logic     rise;
    logic     ws_s;
    logic     sd_s;
    fmt_cfg_t cfg;

    asr_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (bclk_i),
        .ws_i   (wclk_i),
        .sd_i   (sdata_i),
        .rise_o (rise),
        .ws_o   (ws_s),
        .sd_o   (sd_s)
    );

    asr_mode_dec dec_i (
        .m0_i  (fmt_m0_i),
        .m1_i  (fmt_m1_i),
        .i2s_i (fmt_i2s_i),
        .cfg_o (cfg)
    );

    asr_deser deser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .ws_i    (ws_s),
        .sd_i    (sd_s),
        .cfg_i   (cfg),
        .data_o  (smp_data_o),
        .valid_o (smp_valid_o),
        .left_o  (smp_left_o),
        .frame_o (frame_valid_o)
    );

endmodule

// File: rtl/asr_checker.sv
`timescale 1ns/1ps
module asr_checker
    import asr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fmt_m0_i,
    input logic              fmt_m1_i,
    input logic              fmt_i2s_i,
    input logic [DATA_W-1:0] smp_data_o,
    input logic              smp_valid_o,
    input logic              smp_left_o,
    input logic              frame_valid_o
);

    logic narrow_fmt;
    logic mid_fmt;

    assign narrow_fmt = fmt_i2s_i || (fmt_m0_i == fmt_m1_i);
    assign mid_fmt    = !fmt_i2s_i && fmt_m0_i && !fmt_m1_i;

    AST_FRAME_ON_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |-> (smp_valid_o && !smp_left_o)); // R10

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |=> !smp_valid_o); // R10

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_o |=> (smp_valid_o || $stable(smp_data_o))); // R10

    AST_FILL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && narrow_fmt) |-> (smp_data_o[7:0] == 8'h00)); // R3

    AST_FILL_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && mid_fmt) |-> (smp_data_o[3:0] == 4'h0)); // R4

endmodule

bind audio_ser_rx asr_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fmt_m0_i      (fmt_m0_i),
    .fmt_m1_i      (fmt_m1_i),
    .fmt_i2s_i     (fmt_i2s_i),
    .smp_data_o    (smp_data_o),
    .smp_valid_o   (smp_valid_o),
    .smp_left_o    (smp_left_o),
    .frame_valid_o (frame_valid_o)
);

// File: tb/audio_ser_rx_tb_top.sv
`timescale 1ns/1ps
module audio_ser_rx_tb_top;

    localparam int CAP_N  = 512;
    localparam int FRAMES = 3;
    localparam int HOLD   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic        sdata = 1'b0;
    logic        m0 = 1'b0;
    logic        m1 = 1'b0;
    logic        i2s = 1'b0;
    logic [23:0] smp_data;
    logic        smp_valid;
    logic        smp_left;
    logic        frame_valid;

    int n_chk = 0;
    int n_fail = 0;
    int cap_n = 0;
    logic [23:0] cap_data [CAP_N];
    logic        cap_left [CAP_N];
    logic        cap_frame [CAP_N];

    always #4 clk = ~clk;

    audio_ser_rx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_i        (bclk),
        .wclk_i        (wclk),
        .sdata_i       (sdata),
        .fmt_m0_i      (m0),
        .fmt_m1_i      (m1),
        .fmt_i2s_i     (i2s),
        .smp_data_o    (smp_data),
        .smp_valid_o   (smp_valid),
        .smp_left_o    (smp_left),
        .frame_valid_o (frame_valid)
    );

    always @(negedge clk) begin
        if (smp_valid) begin
            if (cap_n < CAP_N) begin
                cap_data[cap_n]  <= smp_data;
                cap_left[cap_n]  <= smp_left;
                cap_frame[cap_n] <= frame_valid;
            end
            cap_n <= cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] raw_val(input int seed, input int k);
        logic [31:0] h;
        if (seed == 0) begin
            case (k)
                0: return 24'h800000;
                1: return 24'h7FFFFF;
                2: return 24'hFFFFFF;
                3: return 24'h000100;
                4: return 24'hA5A5A5;
                default: return 24'h5A5A5A;
            endcase
        end
        h = 32'(seed) * 32'h0019_660D + 32'(k) * 32'h3C6E_F35F + 32'h0101_0101;
        return h[27:4];
    endfunction

    function automatic logic [23:0] mask_of(input int n);
        return 24'hFFFFFF << (24 - n);
    endfunction

    function automatic logic slot_bit(input logic [23:0] v, input int j, input int slots,
                                      input int n, input bit rj, input bit is_i2s);
        logic g;
        g = ~j[0];
        if (rj) begin
            if (j >= slots - n) return v[23 - (j - (slots - n))];
            return g;
        end
        if (is_i2s) begin
            if (j >= 1 && j <= 16) return v[23 - (j - 1)];
            return g;
        end
        if (j < 16) return v[23 - j];
        return g;
    endfunction

    task automatic slot(input logic ws, input logic b);
        wclk  = ws;
        sdata = b;
        bclk  = 1'b0;
        repeat (HOLD) @(negedge clk);
        bclk = 1'b1;
        @(negedge clk);
        sdata = ~b;   // R12: change while bit clock is high
        repeat (HOLD - 1) @(negedge clk);
    endtask

    task automatic half(input logic ws, input logic [23:0] v, input int slots,
                        input int n, input bit rj, input bit is_i2s);
        for (int j = 0; j < slots; j++) begin
            slot(ws, slot_bit(v, j, slots, n, rj, is_i2s));
        end
    endtask

    task automatic run_test(input logic pm0, input logic pm1, input logic pi2s,
                            input int ratio, input int seed, input string tag);
        int  n;
        bit  rj;
        int  slots;
        int  base;
        int  got;
        int  exp_cnt;
        logic lhi;
        logic [23:0] expv;

        rst_n = 1'b0;
        bclk  = 1'b0;
        wclk  = 1'b0;
        sdata = 1'b0;
        m0 = pm0;
        m1 = pm1;
        i2s = pi2s;
        repeat (3) @(negedge clk);
        check(smp_data == 24'h0 && !smp_valid && !frame_valid, "R1 reset outputs",
              {6'h0, smp_valid, frame_valid, smp_data}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        n  = pi2s ? 16 : (pm0 && pm1) ? 16 : pm1 ? 24 : pm0 ? 20 : 16;
        rj = !pi2s && !(pm0 && pm1);
        slots = ratio / 2;
        lhi = pi2s ? 1'b0 : 1'b1;
        base = cap_n;

        half(~lhi, 24'hC3C3C3, slots, n, rj, pi2s);
        for (int f = 0; f < FRAMES; f++) begin
            half(lhi,  raw_val(seed, 2 * f),     slots, n, rj, pi2s);
            half(~lhi, raw_val(seed, 2 * f + 1), slots, n, rj, pi2s);
        end
        half(lhi, 24'h000000, slots, n, rj, pi2s);
        bclk = 1'b0;
        repeat (10) @(negedge clk);

        got = cap_n - base;
        exp_cnt = 2 * FRAMES + (rj ? 0 : 1);
        check(got == exp_cnt, {tag, " sample count R10 R11"}, 32'(got), 32'(exp_cnt));
        for (int i = 0; i < 2 * FRAMES; i++) begin
            if (base + i < CAP_N) begin
                expv = raw_val(seed, i) & mask_of(n);
                check(cap_data[base + i] == expv, {tag, " data R12"},
                      {8'h0, cap_data[base + i]}, {8'h0, expv});
                check(cap_left[base + i] == (i % 2 == 0), {tag, " channel R9"},
                      32'(cap_left[base + i]), 32'(i % 2 == 0));
                check(cap_frame[base + i] == (i % 2 == 1), {tag, " frame strobe R10"},
                      32'(cap_frame[base + i]), 32'(i % 2 == 1));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        run_test(1'b0, 1'b0, 1'b0, 32, 0, "RJ16 x32 R3 R6");
        run_test(1'b0, 1'b0, 1'b0, 64, 3, "RJ16 x64 R3 R6");
        run_test(1'b1, 1'b0, 1'b0, 40, 0, "RJ20 x40 R4 R6");
        run_test(1'b1, 1'b0, 1'b0, 64, 5, "RJ20 x64 R4 R6");
        run_test(1'b0, 1'b1, 1'b0, 48, 0, "RJ24 x48 R5 R6");
        run_test(1'b0, 1'b1, 1'b0, 64, 7, "RJ24 x64 R5 R6");
        run_test(1'b1, 1'b1, 1'b0, 32, 0, "LJ x32 R7");
        run_test(1'b1, 1'b1, 1'b0, 64, 9, "LJ x64 R7");
        run_test(1'b0, 1'b0, 1'b1, 64, 0, "I2S m00 R8 R2");
        run_test(1'b1, 1'b1, 1'b1, 64, 11, "I2S m11 R8 R2");
        run_test(1'b0, 1'b1, 1'b1, 64, 13, "I2S m10 R8 R2");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(smp_data == 24'h0 && !smp_valid, "R1 final reset", {8'h0, smp_data}, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule